// File: doc/BRIEF.md
# Registered Four-Bit Lookahead ALU Slice

This block is an arithmetic logic unit slice that offers thirty-two functions on two operands. A four-bit select code and a mode bit pick the function. When the mode bit is high, the slice computes one of sixteen bitwise logic functions and no carry passes between bits. When the mode bit is low, it computes one of sixteen arithmetic functions, and the carries come from a lookahead network instead of a ripple chain. The slice also produces group propagate and group generate. An external lookahead stage uses these to join several slices into a wider word.

All fourteen input bits go into flip-flops before the combinational core, and all eight output bits go into flip-flops after it. A result therefore appears at the ports on the second rising clock edge after its operands are presented. The operand width and the carry network style are parameters.

Top module: `lookahead_alu_slice`

## Requirements
- R1: A synchronous reset, sampled high on a rising edge, clears every input and output flip-flop. After that edge, `f_o`, `cout_o`, `grp_prop_o`, `grp_gen_o` and `a_eq_b_o` all read 0.
- R2: Inputs present before rising edge k are captured at edge k. Their result is visible on the outputs after edge k+1, and not after edge k.
- R3: With `mode_i`=0 and `sel_i`=4'b1001, `f_o` equals `a_i + b_i + cin_i`, modulo 2^WIDTH.
- R4: With `mode_i`=0 and `sel_i`=4'b0110, `f_o` equals `a_i - b_i - 1 + cin_i`, modulo 2^WIDTH.
- R5: For bit i, the bench defines U_i = A_i | (B_i & S0) | (~B_i & S1) and V_i = (A_i & ~B_i & S2) | (A_i & B_i & S3). With `mode_i`=0, `f_o` equals U + V + `cin_i` modulo 2^WIDTH, where U and V are read as unsigned words.
- R6: With `mode_i`=1, each result bit equals U_i XOR V_i. The result is unaffected by `cin_i` and by neighbouring bits. For example, `sel_i`=4'b1001 gives A XOR B.
- R7: `grp_prop_o` is 1 exactly when every U_i is 1. `grp_gen_o` is 1 exactly when U + V is at least 2^WIDTH. This holds in both modes.
- R8: `cout_o` equals `grp_gen_o | (grp_prop_o & cin_i)` in both modes. In arithmetic mode this is the carry out of R5's sum.
- R9: `a_eq_b_o` is 1 exactly when every bit of `f_o` is 1. With `sel_i`=4'b0110, `mode_i`=0 and `cin_i`=0, this means the operands are equal.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| a_i | input | WIDTH | Operand A |
| b_i | input | WIDTH | Operand B |
| sel_i | input | 4 | Function select code |
| mode_i | input | 1 | 1 selects logic functions, 0 selects arithmetic |
| cin_i | input | 1 | Carry in, active high |
| f_o | output | WIDTH | Registered result |
| cout_o | output | 1 | Registered carry out |
| grp_prop_o | output | 1 | Registered group propagate |
| grp_gen_o | output | 1 | Registered group generate |
| a_eq_b_o | output | 1 | Registered all-ones result flag |

## Verification
The bench builds two copies of the slice side by side. Both use WIDTH=4. One uses the lookahead carry network (CARRY_LOOKAHEAD=1) and the other uses the ripple variant (CARRY_LOOKAHEAD=0). A width of four makes the full input space small enough to cover: all 16 select codes, both modes, all operand pairs and both carry-in values. This exhausts every carry pattern, every group generate and propagate case, and every all-ones result. Feeding the same stimulus to both carry networks shows that the two generate branches agree on every one of those patterns.

// File: rtl/alu_slice_pkg.sv
package alu_slice_pkg;

   typedef enum logic {
      MODE_ARITH = 1'b0,
      MODE_LOGIC = 1'b1
   } alu_mode_e;

   typedef struct packed {
      logic [3:0] sel;
      alu_mode_e  mode;
      logic       cin;
   } alu_ctl_t;

   localparam int          SEL_W    = 4;
   localparam logic [3:0]  SEL_ADD  = 4'b1001;
   localparam logic [3:0]  SEL_SUB  = 4'b0110;
   localparam logic [3:0]  SEL_LXOR = 4'b1001;

endpackage

// File: rtl/alu_bit_terms.sv
module alu_bit_terms
   import alu_slice_pkg::*;
#(
   parameter int WIDTH = 4
) (
   input  logic [WIDTH-1:0] a_i,
   input  logic [WIDTH-1:0] b_i,
   input  logic [SEL_W-1:0] sel_i,
   output logic [WIDTH-1:0] prop_o,
   output logic [WIDTH-1:0] gen_o
);

   // Per-bit propagate and generate terms; generate always implies propagate.
   for (genvar i = 0; i < WIDTH; i++) begin : g_bit
      assign prop_o[i] = a_i[i] | (b_i[i] & sel_i[0]) | (~b_i[i] & sel_i[1]);
      assign gen_o[i]  = (a_i[i] & ~b_i[i] & sel_i[2]) | (a_i[i] & b_i[i] & sel_i[3]);
   end

endmodule

// File: rtl/alu_carry_net.sv
module alu_carry_net #(
   parameter int WIDTH           = 4,
   parameter bit CARRY_LOOKAHEAD = 1'b1
) (
   input  logic [WIDTH-1:0] prop_i,
   input  logic [WIDTH-1:0] gen_i,
   input  logic             cin_i,
   input  logic             inhibit_i,
   output logic [WIDTH-1:0] carry_o,
   output logic             grp_prop_o,
   output logic             grp_gen_o
);

   logic [WIDTH-1:0] raw_carry;

   // Flattened two-level carry into position idx.
   function automatic logic flat_carry(input logic [WIDTH-1:0] p,
                                       input logic [WIDTH-1:0] g,
                                       input logic c0,
                                       input int idx);
      logic acc;
      logic term;
      acc = 1'b0;
      for (int j = 0; j < WIDTH; j++) begin
         if (j < idx) begin
            term = g[j];
            for (int k = 0; k < WIDTH; k++) begin
               if (k > j && k < idx) term = term & p[k];
            end
            acc = acc | term;
         end
      end
      term = c0;
      for (int k = 0; k < WIDTH; k++) begin
         if (k < idx) term = term & p[k];
      end
      return acc | term;
   endfunction

   if (CARRY_LOOKAHEAD) begin : g_lookahead
      for (genvar i = 0; i < WIDTH; i++) begin : g_pos
         assign raw_carry[i] = flat_carry(prop_i, gen_i, cin_i, i);
      end
      assign grp_gen_o = flat_carry(prop_i, gen_i, 1'b0, WIDTH);
   end else begin : g_ripple
      logic [WIDTH:0] gchain;
      assign raw_carry[0] = cin_i;
      assign gchain[0]    = 1'b0;
      for (genvar i = 1; i < WIDTH; i++) begin : g_pos
         assign raw_carry[i] = gen_i[i-1] | (prop_i[i-1] & raw_carry[i-1]);
      end
      for (genvar i = 0; i < WIDTH; i++) begin : g_grp
         assign gchain[i+1] = gen_i[i] | (prop_i[i] & gchain[i]);
      end
      assign grp_gen_o = gchain[WIDTH];
   end

   assign grp_prop_o = &prop_i;
   assign carry_o    = inhibit_i ? '0 : raw_carry;

endmodule

// File: rtl/lookahead_alu_slice.sv
module lookahead_alu_slice
   import alu_slice_pkg::*;
#(
   parameter int WIDTH           = 4,
   parameter bit CARRY_LOOKAHEAD = 1'b1
) (
   input  logic             clk,
   input  logic             rst,
   input  logic [WIDTH-1:0] a_i,
   input  logic [WIDTH-1:0] b_i,
   input  logic [3:0]       sel_i,
   input  logic             mode_i,
   input  logic             cin_i,
   output logic [WIDTH-1:0] f_o,
   output logic             cout_o,
   output logic             grp_prop_o,
   output logic             grp_gen_o,
   output logic             a_eq_b_o
);

   localparam logic [WIDTH-1:0] ONE_W = WIDTH'(1);

   if (WIDTH < 1 || WIDTH > 16) begin : g_width_bad
      $error("lookahead_alu_slice: WIDTH must lie in 1..16");
   end

   // Input capture stage.
   logic [WIDTH-1:0] a_q, b_q;
   alu_ctl_t         ctl_q, ctl_d;

   assign ctl_d.sel  = sel_i;
   assign ctl_d.mode = alu_mode_e'(mode_i);
   assign ctl_d.cin  = cin_i;

   always_ff @(posedge clk) begin
      if (rst) begin
         a_q   <= '0;
         b_q   <= '0;
         ctl_q <= '0;
      end else begin
         a_q   <= a_i;
         b_q   <= b_i;
         ctl_q <= ctl_d;
      end
   end

   // Combinational core.
   logic [WIDTH-1:0] prop, gen, carry;
   logic             gp, gg;
   logic [WIDTH-1:0] f_d;
   logic             cout_d;

   alu_bit_terms #(.WIDTH(WIDTH)) i_terms (
      .a_i    (a_q),
      .b_i    (b_q),
      .sel_i  (ctl_q.sel),
      .prop_o (prop),
      .gen_o  (gen)
   );

   alu_carry_net #(.WIDTH(WIDTH), .CARRY_LOOKAHEAD(CARRY_LOOKAHEAD)) i_carry (
      .prop_i     (prop),
      .gen_i      (gen),
      .cin_i      (ctl_q.cin),
      .inhibit_i  (ctl_q.mode == MODE_LOGIC),
      .carry_o    (carry),
      .grp_prop_o (gp),
      .grp_gen_o  (gg)
   );

   assign f_d    = (prop & ~gen) ^ carry;
   assign cout_d = gg | (gp & ctl_q.cin);

   // Output capture stage.
   always_ff @(posedge clk) begin
      if (rst) begin
         f_o        <= '0;
         cout_o     <= 1'b0;
         grp_prop_o <= 1'b0;
         grp_gen_o  <= 1'b0;
         a_eq_b_o   <= 1'b0;
      end else begin
         f_o        <= f_d;
         cout_o     <= cout_d;
         grp_prop_o <= gp;
         grp_gen_o  <= gg;
         a_eq_b_o   <= &f_d;
      end
   end

   // Checks.
   logic [WIDTH-1:0] cin_ext;
   assign cin_ext = WIDTH'(ctl_q.cin);

   assert_reset_clear_R1: assert property (@(posedge clk)
      rst |=> (f_o == '0 && !cout_o && !grp_prop_o && !grp_gen_o && !a_eq_b_o));

   assert_add_R3: assert property (@(posedge clk) disable iff (rst)
      (!$past(rst) && $past(ctl_q.mode) == MODE_ARITH && $past(ctl_q.sel) == SEL_ADD)
      |-> f_o == $past(a_q + b_q + cin_ext));

   assert_sub_R4: assert property (@(posedge clk) disable iff (rst)
      (!$past(rst) && $past(ctl_q.mode) == MODE_ARITH && $past(ctl_q.sel) == SEL_SUB)
      |-> f_o == $past(a_q - b_q - ONE_W + cin_ext));

   assert_logic_xor_R6: assert property (@(posedge clk) disable iff (rst)
      (!$past(rst) && $past(ctl_q.mode) == MODE_LOGIC && $past(ctl_q.sel) == SEL_LXOR)
      |-> f_o == $past(a_q ^ b_q));

   assert_carry_out_R8: assert property (@(posedge clk) disable iff (rst)
      !$past(rst) |-> cout_o == (grp_gen_o | (grp_prop_o & $past(ctl_q.cin))));

   assert_equal_flag_R9: assert property (@(posedge clk) disable iff (rst)
      a_eq_b_o == (&f_o));

endmodule

// File: tb/test_lookahead_alu_slice.sv
module test_lookahead_alu_slice;

   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic [3:0] a = '0, b = '0, s = '0;
   logic       m = 1'b0, cin = 1'b0;

   logic [3:0] f_la, f_rp;
   logic       co_la, p_la, g_la, eq_la;
   logic       co_rp, p_rp, g_rp, eq_rp;

   int  n_run  = 0;
   int  n_fail = 0;
   bit  done   = 1'b0;

   always #4 clk = ~clk;

   lookahead_alu_slice #(.WIDTH(4), .CARRY_LOOKAHEAD(1'b1)) i_lookahead_alu_slice (
      .clk(clk), .rst(rst), .a_i(a), .b_i(b), .sel_i(s), .mode_i(m), .cin_i(cin),
      .f_o(f_la), .cout_o(co_la), .grp_prop_o(p_la), .grp_gen_o(g_la), .a_eq_b_o(eq_la));

   lookahead_alu_slice #(.WIDTH(4), .CARRY_LOOKAHEAD(1'b0)) i_ripple (
      .clk(clk), .rst(rst), .a_i(a), .b_i(b), .sel_i(s), .mode_i(m), .cin_i(cin),
      .f_o(f_rp), .cout_o(co_rp), .grp_prop_o(p_rp), .grp_gen_o(g_rp), .a_eq_b_o(eq_rp));

   typedef struct packed {
      logic [3:0] f;
      logic       co, p, g, eq;
      logic       m;
      logic [3:0] s;
   } exp_t;

   exp_t pipe[$];

   function automatic exp_t model(input logic [3:0] av, input logic [3:0] bv,
                                  input logic [3:0] sv, input logic mv, input logic cv);
      exp_t e;
      logic [3:0] uu, vv;
      int sum_uv;
      uu = av | (bv & {4{sv[0]}}) | (~bv & {4{sv[1]}});
      vv = (av & ~bv & {4{sv[2]}}) | (av & bv & {4{sv[3]}});
      sum_uv = int'(uu) + int'(vv);
      e.f  = mv ? (uu ^ vv) : 4'((sum_uv + int'(cv)) % 16);
      e.p  = (uu == 4'hF);
      e.g  = (sum_uv >= 16);
      e.co = ((sum_uv + int'(cv)) >= 16);
      e.eq = (e.f == 4'hF);
      e.m  = mv;
      e.s  = sv;
      return e;
   endfunction

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      n_run++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic cmp_one(input string who, input logic [3:0] f, input logic co,
                          input logic p, input logic g, input logic eq, input exp_t e);
      string ftag;
      ftag = e.m ? "R6 logic" : (e.s == 4'b1001 ? "R3 add" :
                                 (e.s == 4'b0110 ? "R4 sub" : "R5 arith"));
      chk(f  == e.f,  {ftag, " F ", who}, int'(f), int'(e.f));
      chk(p  == e.p,  {"R7 P ", who},     int'(p), int'(e.p));
      chk(g  == e.g,  {"R7 G ", who},     int'(g), int'(e.g));
      chk(co == e.co, {"R8 cout ", who},  int'(co), int'(e.co));
      chk(eq == e.eq, {"R9 eq ", who},    int'(eq), int'(e.eq));
   endtask

   task automatic check_zero(input string tag);
      chk(f_la == 4'd0 && !co_la && !p_la && !g_la && !eq_la, {tag, " lookahead"},
          int'({eq_la, g_la, p_la, co_la, f_la}), 0);
      chk(f_rp == 4'd0 && !co_rp && !p_rp && !g_rp && !eq_rp, {tag, " ripple"},
          int'({eq_rp, g_rp, p_rp, co_rp, f_rp}), 0);
   endtask

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      if (!done) begin
         n_fail++;
         $display("FAIL R2 watchdog expired actual=%0d expected=%0d", 150000, 0);
         $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

   initial begin : main
      // R1: reset state
      repeat (3) @(posedge clk);
      @(negedge clk);
      check_zero("R1 reset");

      // R2: two-edge latency, 3+4 add
      rst = 1'b0; a = 4'd3; b = 4'd4; s = 4'b1001; m = 1'b0; cin = 1'b0;
      @(negedge clk);
      chk(f_la == 4'd0, "R2 not yet after one edge", int'(f_la), 0);
      @(negedge clk);
      chk(f_la == 4'd7, "R2 visible after two edges", int'(f_la), 7);
      chk(f_rp == 4'd7, "R2 ripple visible after two edges", int'(f_rp), 7);

      // Exhaustive sweep, compared every clock
      pipe.delete();
      for (int sv = 0; sv < 16; sv++) begin
         for (int mv = 0; mv < 2; mv++) begin
            for (int av = 0; av < 16; av++) begin
               for (int bv = 0; bv < 16; bv++) begin
                  for (int cv = 0; cv < 2; cv++) begin
                     @(negedge clk);
                     if (pipe.size() == 2) begin
                        exp_t e;
                        e = pipe.pop_front();
                        cmp_one("lookahead", f_la, co_la, p_la, g_la, eq_la, e);
                        cmp_one("ripple", f_rp, co_rp, p_rp, g_rp, eq_rp, e);
                     end
                     a = 4'(av); b = 4'(bv); s = 4'(sv); m = mv[0]; cin = cv[0];
                     pipe.push_back(model(a, b, s, m, cin));
                  end
               end
            end
         end
      end
      while (pipe.size() > 0) begin
         @(negedge clk);
         if (pipe.size() == 2 || pipe.size() == 1) begin
            exp_t e;
            if (pipe.size() == 2) begin
               e = pipe.pop_front();
            end else begin
               e = pipe.pop_front();
            end
            cmp_one("lookahead", f_la, co_la, p_la, g_la, eq_la, e);
            cmp_one("ripple", f_rp, co_rp, p_rp, g_rp, eq_rp, e);
         end
      end

      // Mid-run reset with a nonzero result present: 7+8 = 15, eq set
      a = 4'd7; b = 4'd8; s = 4'b1001; m = 1'b0; cin = 1'b0;
      repeat (2) @(negedge clk);
      chk(f_la == 4'hF, "R3 7+8 before reset", int'(f_la), 15);
      chk(eq_la == 1'b1, "R9 all-ones before reset", int'(eq_la), 1);
      rst = 1'b1;
      @(negedge clk);
      check_zero("R1 mid-run reset");

      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

endmodule